// File: doc/BRIEF.md
# Converter Sample Test-Pattern Checker

This block watches the sample stream that a receive link delivers to the application and checks it against a known test pattern. In ramp mode it expects every converter's samples to count upward by one from wherever the stream first appears. It also expects all converters to carry the same value in the same cycle. In PRBS mode it treats each converter's samples as a serial pseudo-random bit stream. It predicts every bit from bits it has already received, so it locks on by itself after a short run of input.

Alongside the sample path, the block checks the 6-bit command-channel words of every lane for a wrapping ramp that is identical across lanes. Two sticky flags report any mismatch: one for samples and one for command words. They stay set until a clear pulse. Any change of the pattern selection makes the sample checkers seed again.

Top module: `sample_pattern_checker`

## Requirements
- R1: While `rst` is high, and at the first falling edge after it is released, `data_err` and `cmd_err` are 0 and every checker is unseeded.
- R2: With `mode_sel`=0 (ramp), the first valid sample of each converter after reset or after a selection change is taken as that converter's start value and is never flagged by the sequence check. Converter c occupies `smp_data[c*SAMP_W +: SAMP_W]`.
- R3: In ramp mode, each later valid sample of a converter must equal its expected value plus one modulo 2^SAMP_W, so all-ones is followed by 0. A mismatch sets `data_err` at the clock edge that samples it.
- R4: In ramp mode, a valid cycle in which any converter's sample differs from converter 0's sample sets `data_err`. In PRBS mode converters are not compared with each other.
- R5: With `mode_sel`=1 (PRBS), each converter's samples form one serial stream, most significant bit first, where bit k equals bit k-a XOR bit k-b. `prbs_order` selects (a,b): 0 gives (7,6), 1 gives (9,5), 2 gives (15,14), 3 gives (23,18). Any compared bit that breaks the recurrence sets `data_err`.
- R6: In PRBS mode, the first ceil(64/SAMP_W) valid samples of each converter after reset or a selection change only load its history and are never compared. Every later valid sample is compared in full.
- R7: Each lane's first valid command word (lane l at `cmd_data[6*l +: 6]`) is its start value. Each later valid word must be the previous expected value plus one, wrapping from 0x3F to 0x00. A mismatch sets `cmd_err`.
- R8: A valid command cycle in which any lane's word differs from lane 0's word sets `cmd_err`.
- R9: Cycles with `smp_valid`=0 neither advance nor check the sample checkers. Cycles with `cmd_valid`=0 do the same for the command checkers. Whatever data is present in those cycles has no effect.
- R10: Both flags stay set until `err_clr` is high at a clock edge, which clears them. A mismatch seen in the same cycle as `err_clr` is dropped.
- R11: A cycle in which `mode_sel` or `prbs_order` differs from its value in the previous cycle ignores its sample and restarts seeding of all sample checkers. The command checkers are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 0 = ramp check, 1 = PRBS check |
| prbs_order | input | 2 | PRBS polynomial select (see R5) |
| smp_valid | input | 1 | Sample bus holds valid samples this cycle |
| smp_data | input | NUM_CONV*SAMP_W | One sample per converter, converter 0 in the low bits |
| cmd_valid | input | 1 | Command bus holds valid words this cycle |
| cmd_data | input | NUM_LANE*6 | One 6-bit command word per lane, lane 0 in the low bits |
| err_clr | input | 1 | Clear pulse for both error flags |
| data_err | output | 1 | Sticky sample pattern error |
| cmd_err | output | 1 | Sticky command-channel ramp error |

## Verification
Ramp streams are sent with a start near all-ones and random idle gaps filled with garbage, so a wrap fault or a checker that advances on idle cycles shows up as a false error. A skipped value on every converter isolates the sequence check, while one converter carrying its own consistent but offset ramp isolates the cross-converter check. PRBS streams for all four polynomials are joined mid-sequence. This separates a checker that compares during seeding from one that does not, and a flipped bit in the first sample and in the first compared sample marks the seeding boundary. Mode and order changes followed by an unrelated stream show whether seeding restarts, and random ramp runs with one injected fault per run test the sticky flag cycle by cycle.

// File: rtl/smpchk_pkg.sv
package smpchk_pkg;

  typedef enum logic {
    PAT_RAMP = 1'b0,
    PAT_PRBS = 1'b1
  } pat_mode_e;

  localparam int CMD_W     = 6;
  localparam int HIST_W    = 23;
  localparam int SEED_BITS = 64;

  // Predict the next serial bit; h[0] is the most recent bit.
  function automatic logic prbs_predict(input logic [HIST_W-1:0] h,
                                        input logic [1:0]        ord);
    logic p;
    case (ord)
      2'd0:    p = h[6]  ^ h[5];
      2'd1:    p = h[8]  ^ h[4];
      2'd2:    p = h[14] ^ h[13];
      default: p = h[22] ^ h[17];
    endcase
    return p;
  endfunction

endpackage

// File: rtl/smpchk_ramp_lane.sv
module smpchk_ramp_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         step,
  input  logic [W-1:0] data,
  output logic         mis
);

  logic         seeded_q;
  logic [W-1:0] exp_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      seeded_q <= 1'b0;
      exp_q    <= '0;
    end else if (step) begin
      seeded_q <= 1'b1;
      exp_q    <= seeded_q ? (exp_q + W'(1)) : (data + W'(1));
    end
  end

  assign mis = step && seeded_q && (data != exp_q);

endmodule

// File: rtl/smpchk_prbs_lane.sv
module smpchk_prbs_lane
  import smpchk_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         step,
  input  logic [1:0]   ord,
  input  logic [W-1:0] data,
  output logic         mis
);

  localparam int SEED_SMP = (SEED_BITS + W - 1) / W;
  localparam int CNT_W    = $clog2(SEED_SMP + 1);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic              bit_mis;
  logic              locked;

  always_comb begin
    logic [HIST_W-1:0] h;
    h       = hist_q;
    bit_mis = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (data[i] != prbs_predict(h, ord)) bit_mis = 1'b1;
      h = {h[HIST_W-2:0], data[i]};
    end
    hist_nx = h;
  end

  assign locked = (cnt_q == CNT_W'(SEED_SMP));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (step) begin
      hist_q <= hist_nx;
      if (!locked) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign mis = step && locked && bit_mis;

endmodule

// File: rtl/sample_pattern_checker.sv
module sample_pattern_checker
  import smpchk_pkg::*;
#(
  parameter int NUM_CONV = 4,
  parameter int SAMP_W   = 8,
  parameter int NUM_LANE = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mode_sel,
  input  logic [1:0]                 prbs_order,
  input  logic                       smp_valid,
  input  logic [NUM_CONV*SAMP_W-1:0] smp_data,
  input  logic                       cmd_valid,
  input  logic [NUM_LANE*CMD_W-1:0]  cmd_data,
  input  logic                       err_clr,
  output logic                       data_err,
  output logic                       cmd_err
);

  pat_mode_e     mode_cur;
  pat_mode_e     mode_q;
  logic [1:0]    ord_q;
  logic          sel_chg;
  logic          ramp_step;
  logic          prbs_step;

  logic [NUM_CONV-1:0] ramp_mis;
  logic [NUM_CONV-1:0] prbs_mis;
  logic [NUM_LANE-1:0] cmd_mis;
  logic                conv_diff;
  logic                lane_diff;
  logic                data_hit;
  logic                cmd_hit;

  assign mode_cur = pat_mode_e'(mode_sel);

  always_ff @(posedge clk) begin
    mode_q <= mode_cur;
    ord_q  <= prbs_order;
  end

  assign sel_chg   = (mode_cur != mode_q) || (prbs_order != ord_q);
  assign ramp_step = smp_valid && !sel_chg && (mode_cur == PAT_RAMP);
  assign prbs_step = smp_valid && !sel_chg && (mode_cur == PAT_PRBS);

  for (genvar c = 0; c < NUM_CONV; c++) begin : g_conv
    smpchk_ramp_lane #(.W(SAMP_W)) u_ramp (
      .clk     (clk),
      .rst     (rst),
      .restart (sel_chg),
      .step    (ramp_step),
      .data    (smp_data[c*SAMP_W +: SAMP_W]),
      .mis     (ramp_mis[c])
    );
    smpchk_prbs_lane #(.W(SAMP_W)) u_prbs (
      .clk     (clk),
      .rst     (rst),
      .restart (sel_chg),
      .step    (prbs_step),
      .ord     (prbs_order),
      .data    (smp_data[c*SAMP_W +: SAMP_W]),
      .mis     (prbs_mis[c])
    );
  end

  for (genvar l = 0; l < NUM_LANE; l++) begin : g_lane
    smpchk_ramp_lane #(.W(CMD_W)) u_cmd (
      .clk     (clk),
      .rst     (rst),
      .restart (1'b0),
      .step    (cmd_valid),
      .data    (cmd_data[l*CMD_W +: CMD_W]),
      .mis     (cmd_mis[l])
    );
  end

  always_comb begin
    conv_diff = 1'b0;
    for (int c = 1; c < NUM_CONV; c++)
      if (smp_data[c*SAMP_W +: SAMP_W] != smp_data[SAMP_W-1:0]) conv_diff = 1'b1;
    lane_diff = 1'b0;
    for (int l = 1; l < NUM_LANE; l++)
      if (cmd_data[l*CMD_W +: CMD_W] != cmd_data[CMD_W-1:0]) lane_diff = 1'b1;
  end

  assign data_hit = (|ramp_mis) || (|prbs_mis) || (ramp_step && conv_diff);
  assign cmd_hit  = (|cmd_mis) || (cmd_valid && lane_diff);

  always_ff @(posedge clk) begin
    if (rst || err_clr) begin
      data_err <= 1'b0;
      cmd_err  <= 1'b0;
    end else begin
      data_err <= data_err | data_hit;
      cmd_err  <= cmd_err | cmd_hit;
    end
  end

endmodule

// File: rtl/smpchk_props.sv
module smpchk_props #(
  parameter int NUM_CONV = 4,
  parameter int SAMP_W   = 8,
  parameter int NUM_LANE = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       mode_sel,
  input logic [1:0]                 prbs_order,
  input logic                       smp_valid,
  input logic [NUM_CONV*SAMP_W-1:0] smp_data,
  input logic                       cmd_valid,
  input logic [NUM_LANE*6-1:0]      cmd_data,
  input logic                       err_clr,
  input logic                       data_err,
  input logic                       cmd_err
);

  logic c_diff;
  logic l_diff;

  always_comb begin
    c_diff = 1'b0;
    for (int c = 1; c < NUM_CONV; c++)
      c_diff = c_diff | (smp_data[c*SAMP_W +: SAMP_W] != smp_data[0 +: SAMP_W]);
    l_diff = 1'b0;
    for (int l = 1; l < NUM_LANE; l++)
      l_diff = l_diff | (cmd_data[l*6 +: 6] != cmd_data[0 +: 6]);
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!data_err && !cmd_err));

  assert_conv_match_R4: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !err_clr && !mode_sel && (mode_sel == $past(mode_sel)) &&
     (prbs_order == $past(prbs_order)) && c_diff) |=> data_err);

  assert_lane_match_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !err_clr && l_diff) |=> cmd_err);

  assert_data_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && !data_err) |=> !data_err);

  assert_cmd_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid && !cmd_err) |=> !cmd_err);

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    err_clr |=> (!data_err && !cmd_err));

  assert_data_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (data_err && !err_clr) |=> data_err);

  assert_cmd_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_err && !err_clr) |=> cmd_err);

endmodule

bind sample_pattern_checker smpchk_props #(
  .NUM_CONV (NUM_CONV),
  .SAMP_W   (SAMP_W),
  .NUM_LANE (NUM_LANE)
) u_props (
  .clk        (clk),
  .rst        (rst),
  .mode_sel   (mode_sel),
  .prbs_order (prbs_order),
  .smp_valid  (smp_valid),
  .smp_data   (smp_data),
  .cmd_valid  (cmd_valid),
  .cmd_data   (cmd_data),
  .err_clr    (err_clr),
  .data_err   (data_err),
  .cmd_err    (cmd_err)
);

// File: tb/sample_pattern_checker_bench.sv
module sample_pattern_checker_bench;

  localparam int NC   = 4;
  localparam int SW   = 8;
  localparam int NL   = 2;
  localparam int SEED = (64 + SW - 1) / SW;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            mode_sel = 1'b0;
  logic [1:0]      prbs_order = 2'd0;
  logic            smp_valid = 1'b0;
  logic [NC*SW-1:0] smp_data = '0;
  logic            cmd_valid = 1'b0;
  logic [NL*6-1:0] cmd_data = '0;
  logic            err_clr = 1'b0;
  logic            data_err;
  logic            cmd_err;

  int n_tests = 0;
  int n_fail  = 0;
  logic [SW-1:0] rv;
  logic [5:0]    cv;
  logic [22:0]   gh [NC];

  always #2.5 clk = ~clk;

  sample_pattern_checker #(.NUM_CONV(NC), .SAMP_W(SW), .NUM_LANE(NL)) u_sample_pattern_checker (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .prbs_order(prbs_order),
    .smp_valid(smp_valid), .smp_data(smp_data), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .err_clr(err_clr), .data_err(data_err), .cmd_err(cmd_err));

  task automatic chk(input logic act, input logic exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; smp_valid = 1'b0; cmd_valid = 1'b0; err_clr = 1'b0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic garbage();
    for (int c = 0; c < NC; c++) smp_data[c*SW +: SW] = SW'($urandom);
  endtask

  // Ramp samples with random idle gaps; identical on all converters.
  task automatic ramp_run(input int n, input int gap_pct);
    for (int k = 0; k < n; k++) begin
      while ($urandom_range(99) < gap_pct) begin
        smp_valid = 1'b0; garbage(); tick();
      end
      smp_valid = 1'b1;
      for (int c = 0; c < NC; c++) smp_data[c*SW +: SW] = rv;
      tick();
      rv = rv + SW'(1);
    end
    smp_valid = 1'b0;
  endtask

  function automatic logic gen_bit(input logic [22:0] h, input logic [1:0] o);
    case (o)
      2'd0:    return h[6] ^ h[5];
      2'd1:    return h[8] ^ h[4];
      2'd2:    return h[14] ^ h[13];
      default: return h[22] ^ h[17];
    endcase
  endfunction

  task automatic prbs_init();
    for (int c = 0; c < NC; c++) gh[c] = 23'($urandom) | 23'd1;
    for (int c = 0; c < NC; c++)
      for (int j = 0; j < 40; j++) gh[c] = {gh[c][21:0], gen_bit(gh[c], prbs_order)};
  endtask

  // PRBS samples; flip_at selects a sample index whose conv-1 bit fbit is inverted.
  task automatic prbs_run(input int n, input int flip_at, input int fbit);
    for (int k = 0; k < n; k++) begin
      for (int c = 0; c < NC; c++) begin
        logic [SW-1:0] s;
        for (int i = SW - 1; i >= 0; i--) begin
          s[i] = gen_bit(gh[c], prbs_order);
          gh[c] = {gh[c][21:0], s[i]};
        end
        if (k == flip_at && c == 1) s[fbit] = ~s[fbit];
        smp_data[c*SW +: SW] = s;
      end
      smp_valid = 1'b1;
      tick();
    end
    smp_valid = 1'b0;
  endtask

  task automatic cmd_run(input int n, input logic [5:0] lane1_off);
    for (int k = 0; k < n; k++) begin
      if ($urandom_range(99) < 30) begin
        cmd_valid = 1'b0; cmd_data = 12'($urandom); tick();
      end
      cmd_valid = 1'b1;
      cmd_data = {cv + lane1_off, cv};
      tick();
      cv = cv + 6'd1;
    end
    cmd_valid = 1'b0;
  endtask

  initial begin
    #1000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int sd;
    sd = $urandom(32'd4242);
    tick();
    chk(data_err, 1'b0, "R1 data flag during reset");
    chk(cmd_err, 1'b0, "R1 cmd flag during reset");
    do_reset();
    chk(data_err, 1'b0, "R1 data flag after reset");
    chk(cmd_err, 1'b0, "R1 cmd flag after reset");

    // R2 R3 R9: ramp crossing all-ones with garbage gaps
    rv = 8'hF6;
    ramp_run(30, 30);
    chk(data_err, 1'b0, "R2 R3 R9 ramp with wrap and gaps");

    // R3: skip a value on all converters
    rv = rv + 8'd1;
    ramp_run(1, 0);
    chk(data_err, 1'b1, "R3 skipped ramp value");
    tick(); tick(); tick();
    chk(data_err, 1'b1, "R10 flag held while idle");
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    chk(data_err, 1'b0, "R10 clear pulse");

    // R4: converter 2 on its own consistent but offset ramp
    do_reset();
    rv = 8'h20;
    for (int k = 0; k < 3; k++) begin
      smp_valid = 1'b1;
      for (int c = 0; c < NC; c++) smp_data[c*SW +: SW] = (c == 2) ? rv + 8'd5 : rv;
      tick();
      rv = rv + 8'd1;
    end
    smp_valid = 1'b0;
    chk(data_err, 1'b1, "R4 converters differ in ramp mode");

    // R10: mismatch during clear cycle is dropped
    err_clr = 1'b1; smp_valid = 1'b1;
    for (int c = 0; c < NC; c++) smp_data[c*SW +: SW] = rv + SW'(c);
    tick();
    err_clr = 1'b0; smp_valid = 1'b0;
    chk(data_err, 1'b0, "R10 clear wins over same-cycle mismatch");

    // R11: selection change restarts ramp seeding
    do_reset();
    rv = 8'h10; ramp_run(5, 0);
    mode_sel = 1'b1; smp_valid = 1'b1; garbage(); tick();
    mode_sel = 1'b0; garbage(); tick();
    smp_valid = 1'b0;
    rv = 8'hC8; ramp_run(6, 20);
    chk(data_err, 1'b0, "R11 reseed after mode change");

    // R5 R6: all four polynomials joined mid-stream, then one flip after seeding
    for (int o = 0; o < 4; o++) begin
      do_reset();
      mode_sel = 1'b1; prbs_order = 2'(o);
      tick();
      prbs_init();
      prbs_run(SEED + 12, -1, 0);
      chk(data_err, 1'b0, $sformatf("R5 R6 clean PRBS order code %0d", o));
      prbs_run(4, 2, o);
      chk(data_err, 1'b1, $sformatf("R5 flipped bit order code %0d", o));
    end

    // R6: flip in first sample ignored; flip in first compared sample caught
    do_reset();
    prbs_order = 2'd3; tick();
    prbs_init();
    prbs_run(SEED + 6, 0, SW - 1);
    chk(data_err, 1'b0, "R6 flip inside seeding window");
    do_reset();
    tick();
    prbs_init();
    prbs_run(SEED + 1, SEED, 3);
    chk(data_err, 1'b1, "R6 flip in first compared sample");

    // R11: order change during PRBS restarts seeding
    do_reset();
    prbs_order = 2'd0; tick();
    prbs_init(); prbs_run(SEED + 4, -1, 0);
    prbs_order = 2'd1;
    prbs_init(); prbs_run(SEED + 8, -1, 0);
    chk(data_err, 1'b0, "R11 reseed after order change");
    mode_sel = 1'b0; prbs_order = 2'd0;

    // R7 R8 R9: command channel
    do_reset();
    cv = 6'h3A; cmd_run(20, 6'd0);
    chk(cmd_err, 1'b0, "R7 R9 command ramp with wrap and gaps");
    chk(data_err, 1'b0, "R9 data flag untouched by command traffic");
    cv = cv + 6'd2; cmd_run(1, 6'd0);
    chk(cmd_err, 1'b1, "R7 skipped command word");
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    chk(cmd_err, 1'b0, "R10 command flag clear");
    do_reset();
    cv = 6'h05; cmd_run(4, 6'd1);
    chk(cmd_err, 1'b1, "R8 lanes differ");

    // Random ramp runs, one injected fault per run except the first
    for (int r = 0; r < 4; r++) begin
      int inj;
      int sent;
      logic expf;
      do_reset();
      mode_sel = 1'b0;
      rv = SW'($urandom);
      cv = 6'($urandom);
      inj = (r == 0) ? -1 : $urandom_range(1, 79);
      sent = 0; expf = 1'b0;
      while (sent < 80) begin
        smp_valid = ($urandom_range(99) < 70);
        cmd_valid = ($urandom_range(99) < 50);
        cmd_data = {cv, cv};
        if (smp_valid) begin
          for (int c = 0; c < NC; c++)
            smp_data[c*SW +: SW] = (sent == inj) ? rv + SW'(3) : rv;
          if (sent == inj) expf = 1'b1;
          rv = rv + SW'(1);
          sent++;
        end else garbage();
        if (cmd_valid) cv = cv + 6'd1;
        tick();
        chk(data_err, expf, "R3 R9 R10 random ramp run");
        chk(cmd_err, 1'b0, "R7 random command run");
      end
      smp_valid = 1'b0; cmd_valid = 1'b0;
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule